// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a small on-chip static memory with a clocked interface, meant for cache or staging-buffer use. All inputs (address, access controls, chip selects, byte-lane write enables and write data) are sampled on the rising clock edge into an access stage. The next edge performs the array operation. Read data comes out of a registered output stage. A read therefore shows its data after the second edge that follows the cycle in which its address was presented.

A burst starts with a start cycle, which loads a base address. Later cycles either step a two-bit burst count (advance) or repeat the current word. The two low address bits come from the base and the count. A mode input chooses between XOR-style (interleaved) and wrap-around (linear) ordering. Writes are masked per byte lane, and a global write enable covers every lane. Three chip selects gate the start of an access. The output enable gates the data bus without waiting for a clock. A sleep input freezes the whole pipeline and keeps its contents.

Top module: `psram_burst`

## Requirements
- R1: A read access presented before clock edge E0 drives its word on `rdata` with `rdata_oe` high after edge E1, when `oe_n` is low and `sleep` is low. A write access produces no output slot.
- R2: A cycle with `start` high and all chip selects active begins a new burst at `addr`, whatever burst was in progress. Within a burst the address bits above bit 1 stay equal to the base.
- R3: With `linear` low, the low two address bits of burst step k (k = 0..3, wrapping) are the base's low bits XOR k.
- R4: With `linear` high, the low two address bits of step k are (base low bits + k) modulo 4.
- R5: A cycle inside a burst with `start` and `adv` both low repeats the address of the previous access. A cycle with `adv` high steps the count by one.
- R6: With `gw_n` high and `bw_n` low, a write updates exactly the lanes i whose `be_n[i]` is low. Lane i is `wdata[i*LANE_W +: LANE_W]`. With `bw_n` high and `gw_n` high the cycle is a read and no lane changes.
- R7: With `gw_n` low, all lanes are written, whatever `bw_n` and `be_n` hold.
- R8: A start cycle with `cs_a` low, `cs_b_n` high or `cs_c_n` high makes no access and ends the burst. The output stops driving after the next edge and stays off until a new selected access.
- R9: `rdata_oe` is high only while a read slot is held, `oe_n` is low and `sleep` is low. It follows `oe_n` with no clock edge in between, and `rdata` is all zeros whenever `rdata_oe` is low.
- R10: While `sleep` is high, no access starts, no register or array word changes and the output is off. When `sleep` falls, the pipeline resumes from the state it held.
- R11: A read of an address issued in the cycle right after a byte-masked write to it returns the merged word: the new lanes plus the old contents of the untouched lanes.
- R12: After reset, no burst is active and the output is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Burst base address, used on start cycles |
| start | input | 1 | Begin a new access at `addr` |
| adv | input | 1 | Step the burst count |
| linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| cs_a | input | 1 | Chip select, active high |
| cs_b_n | input | 1 | Chip select, active low |
| cs_c_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bw_n | input | 1 | Byte-lane write enable, active low |
| be_n | input | LANES | Per-lane write select, active low |
| wdata | input | DW | Write data, sampled with its address |
| oe_n | input | 1 | Output enable, active low, not clocked |
| sleep | input | 1 | Power-down freeze, active high |
| rdata | output | DW | Read data, zero when not driving |
| rdata_oe | output | 1 | High when `rdata` drives the bus |

## Verification
The assertions check the properties that hold on every cycle. A read access yields an output slot two edges later and a write yields none. A deselecting start silences the bus one edge after the next. Sleep blocks access and freezes the output slot. The output enable gates `rdata` combinationally. The burst keeps its upper address bits and repeats its address on a hold cycle. The bench scenarios are the only place that shows the data side: the exact XOR and wrap orders, lane merging on a masked write followed at once by a read, a masked write that has no effect, the global write overriding the lane enables, and words that survive a write attempted during sleep. The bench also compares a behavioural model with the outputs on every cycle, over directed and random traffic.

// File: rtl/psram_pkg.sv
package psram_pkg;

  // Low two address bits for burst step cnt from start bits base.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       lin);
    return lin ? (base + cnt) : (base ^ cnt);
  endfunction

endpackage

// File: rtl/psram_burst_ctr.sv
module psram_burst_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          start,
  input  logic          adv,
  input  logic          sel,
  input  logic          linear,
  input  logic [AW-1:0] addr,
  output logic          go,
  output logic [AW-1:0] acc_addr
);
  import psram_pkg::*;

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_nx;
  logic          act_q;

  always_comb begin
    cnt_nx   = start ? 2'd0 : (adv ? cnt_q + 2'd1 : cnt_q);
    go       = !hold && (start ? sel : act_q);
    acc_addr = start ? addr
                     : {base_q[AW-1:2], burst_low(base_q[1:0], cnt_nx, linear)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else if (!hold) begin
      if (start) begin
        act_q  <= sel;
        base_q <= addr;
        cnt_q  <= 2'd0;
      end else if (act_q) begin
        cnt_q  <= cnt_nx;
      end
    end
  end

endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             go,
  input  logic [LANES-1:0] wr_mask,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic rd_en;
  assign rd_en = go && !(|wr_mask);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (go && wr_mask[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)            rd_q      <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/psram_burst.sv
module psram_burst #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             start,
  input  logic             adv,
  input  logic             linear,
  input  logic             cs_a,
  input  logic             cs_b_n,
  input  logic             cs_c_n,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] be_n,
  input  logic [DW-1:0]    wdata,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [DW-1:0]    rdata,
  output logic             rdata_oe
);
  // Named events for the checker
  logic             cs_ok;
  logic             acc_go;
  logic             acc_wr;
  logic [AW-1:0]    acc_addr;
  logic [LANES-1:0] acc_mask;

  // Access stage registers
  logic             s1_go;
  logic [AW-1:0]    s1_addr;
  logic [LANES-1:0] s1_mask;
  logic [DW-1:0]    s1_wdata;

  // Output stage
  logic             rd_valid;
  logic [DW-1:0]    rd_word;

  assign cs_ok = cs_a && !cs_b_n && !cs_c_n;

  always_comb begin
    if (!gw_n)      acc_mask = '1;
    else if (!bw_n) acc_mask = ~be_n;
    else            acc_mask = '0;
  end
  assign acc_wr = |acc_mask;

  psram_burst_ctr #(.AW(AW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (sleep),
    .start    (start),
    .adv      (adv),
    .sel      (cs_ok),
    .linear   (linear),
    .addr     (addr),
    .go       (acc_go),
    .acc_addr (acc_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_go    <= 1'b0;
      s1_addr  <= '0;
      s1_mask  <= '0;
      s1_wdata <= '0;
      rd_valid <= 1'b0;
    end else if (!sleep) begin
      s1_go    <= acc_go;
      s1_addr  <= acc_addr;
      s1_mask  <= acc_mask;
      s1_wdata <= wdata;
      rd_valid <= s1_go && !(|s1_mask);
    end
  end

  psram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .go      (s1_go && !sleep),
    .wr_mask (s1_mask),
    .addr    (s1_addr),
    .wdata   (s1_wdata),
    .rdata   (rd_word)
  );

  assign rdata_oe = rd_valid && !oe_n && !sleep;
  assign rdata    = rdata_oe ? rd_word : '0;

endmodule

// File: rtl/psram_burst_chk.sv
module psram_burst_chk #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          start,
  input logic          adv,
  input logic          linear,
  input logic          cs_ok,
  input logic          acc_go,
  input logic          acc_wr,
  input logic [AW-1:0] acc_addr,
  input logic          rd_valid,
  input logic          oe_n,
  input logic          rdata_oe,
  input logic [DW-1:0] rdata
);

  AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !acc_wr) ##1 !sleep |=> rd_valid); // R1

  AST_WRITE_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && acc_wr) ##1 !sleep |=> !rd_valid); // R1

  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !start && $past(acc_go)) |-> acc_addr[AW-1:2] == $past(acc_addr[AW-1:2])); // R2

  AST_HOLD_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !start && !adv && $past(acc_go) && $stable(linear)) |-> acc_addr == $past(acc_addr)); // R5

  AST_DESEL_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cs_ok) |-> !acc_go); // R8

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cs_ok && !sleep) ##1 !sleep |=> !rdata_oe); // R8

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (!oe_n && rd_valid && !sleep)); // R9

  AST_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == '0); // R9

  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!acc_go && !rdata_oe)); // R10

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> rd_valid == $past(rd_valid)); // R10

endmodule

bind psram_burst psram_burst_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sleep    (sleep),
  .start    (start),
  .adv      (adv),
  .linear   (linear),
  .cs_ok    (cs_ok),
  .acc_go   (acc_go),
  .acc_wr   (acc_wr),
  .acc_addr (acc_addr),
  .rd_valid (rd_valid),
  .oe_n     (oe_n),
  .rdata_oe (rdata_oe),
  .rdata    (rdata)
);

// File: tb/tb_psram_burst.sv
module tb_psram_burst;
  localparam int DEPTH = 256;
  localparam int LW    = 9;
  localparam int NL    = 4;
  localparam int DW    = 36;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0;
  logic          start = 0, adv = 0, linear = 0;
  logic          cs_a = 1, cs_b_n = 0, cs_c_n = 0;
  logic          gw_n = 1, bw_n = 1;
  logic [NL-1:0] be_n = '1;
  logic [DW-1:0] wdata = '0;
  logic          oe_n = 0, sleep = 0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int n_chk = 0;
  int n_fail = 0;

  psram_burst dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .start(start), .adv(adv),
    .linear(linear), .cs_a(cs_a), .cs_b_n(cs_b_n), .cs_c_n(cs_c_n),
    .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n), .wdata(wdata), .oe_n(oe_n),
    .sleep(sleep), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // ---------------- behavioural reference ----------------
  logic [DW-1:0] mdl [DEPTH];
  bit            m_act;
  int            m_base, m_cnt;
  bit            p_go;
  int            p_a;
  logic [NL-1:0] p_msk;
  logic [DW-1:0] p_wd;
  bit            exp_v;
  logic [DW-1:0] exp_d;

  function automatic int order(int b, int k, logic lin);
    if (lin) return (b + k) % 4;
    return b ^ k;
  endfunction

  function automatic logic [DW-1:0] pat(int a);
    return {9'(a), 9'(a + 7), 9'(~a), 9'(a ^ 'h0F0)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_base = 0; m_cnt = 0; p_go = 0; exp_v = 0;
    end else if (!sleep) begin
      if (p_go && p_msk == 0) begin
        exp_v = 1; exp_d = mdl[p_a];
      end else begin
        exp_v = 0;
        if (p_go)
          for (int l = 0; l < NL; l++)
            if (p_msk[l]) mdl[p_a][l*LW +: LW] = p_wd[l*LW +: LW];
      end
      p_go = 0;
      if (start) begin
        if (cs_a && !cs_b_n && !cs_c_n) begin
          m_act = 1; m_base = int'(addr); m_cnt = 0; p_go = 1; p_a = m_base;
        end else m_act = 0;
      end else if (m_act) begin
        if (adv) m_cnt = (m_cnt + 1) % 4;
        p_a  = (m_base / 4) * 4 + order(m_base % 4, m_cnt, linear);
        p_go = 1;
      end
      p_msk = !gw_n ? 4'hF : (!bw_n ? ~be_n : 4'h0);
      p_wd  = wdata;
    end
  end

  // ---------------- checking ----------------
  task automatic want(string tag, bit ok, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cmp(string tag);
    bit eo;
    eo = exp_v && !oe_n && !sleep;
    want({tag, " oe"}, rdata_oe === eo, DW'(rdata_oe), DW'(eo));
    want({tag, " data"}, eo ? (rdata === exp_d) : (rdata === '0), rdata, eo ? exp_d : '0);
  endtask

  task automatic cyc(string tag);
    @(posedge clk); #5; cmp(tag);
  endtask

  task automatic expect_word(string tag, logic [DW-1:0] w);
    want(tag, rdata_oe === 1'b1 && rdata === w, rdata, w);
  endtask

  task automatic idle();
    start = 0; adv = 0; gw_n = 1; bw_n = 1; be_n = '1;
    cs_a = 1; cs_b_n = 0; cs_c_n = 0; oe_n = 0; sleep = 0;
  endtask

  task automatic go_start(int a, logic lin);
    start = 1; adv = 0; addr = 8'(a); linear = lin;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] merged;
    // R12 reset state
    repeat (3) @(posedge clk);
    #5;
    want("R12 reset oe", rdata_oe === 1'b0, DW'(rdata_oe), '0);
    want("R12 reset data", rdata === '0, rdata, '0);
    rst_n = 1;

    // R7 preload every word with a global write, lanes disabled
    for (int a = 0; a < DEPTH; a++) begin
      go_start(a, 0); gw_n = 0; bw_n = 1; be_n = '1; wdata = pat(a);
      cyc("R7");
    end
    idle(); cyc("R7"); cyc("R7");

    // R1 R3 interleaved burst from 0x12: 12 13 10 11
    go_start('h12, 0); cyc("R1");
    start = 0; adv = 1;
    cyc("R1"); expect_word("R1 first word", pat('h12));
    cyc("R3"); expect_word("R3 step1", pat('h13));
    cyc("R3"); expect_word("R3 step2", pat('h10));
    adv = 0;
    cyc("R3"); expect_word("R3 step3", pat('h11));
    idle(); cyc("R3");

    // R4 linear burst from 0x27: 27 24 25 26
    go_start('h27, 1); cyc("R4");
    start = 0; adv = 1;
    cyc("R4"); expect_word("R4 step0", pat('h27));
    cyc("R4"); expect_word("R4 step1", pat('h24));
    cyc("R4"); expect_word("R4 step2", pat('h25));
    adv = 0;
    cyc("R4"); expect_word("R4 step3", pat('h26));
    idle(); cyc("R4");

    // R5 hold repeats the address, then a step
    go_start('h31, 1); cyc("R5");
    start = 0; adv = 0;
    cyc("R5"); expect_word("R5 base", pat('h31));
    cyc("R5"); expect_word("R5 hold", pat('h31));
    adv = 1;
    cyc("R5"); expect_word("R5 hold2", pat('h31));
    adv = 0;
    cyc("R5"); expect_word("R5 stepped", pat('h32));
    idle(); cyc("R5");

    // R6 R11 masked write (lanes 0 and 2) then an immediate read
    go_start('h40, 0); bw_n = 0; be_n = 4'b1010; wdata = 36'h5_A5A5_A5A5;
    cyc("R6");
    go_start('h40, 0); bw_n = 1; be_n = '1;
    cyc("R11");
    start = 0;
    merged = pat('h40);
    merged[0 +: LW]    = wdata[0 +: LW];
    merged[2*LW +: LW] = wdata[2*LW +: LW];
    cyc("R11"); expect_word("R11 merged", merged);
    idle(); cyc("R11");

    // R6 lane enables without bw_n change nothing
    go_start('h41, 0); bw_n = 1; be_n = 4'b0000; wdata = 36'h0_1234_5678;
    cyc("R6");
    go_start('h41, 0); be_n = '1; cyc("R6");
    start = 0;
    cyc("R6"); expect_word("R6 unchanged", pat('h41));
    idle(); cyc("R6");

    // R7 global write overrides disabled lanes
    go_start('h42, 0); gw_n = 0; bw_n = 1; be_n = '1; wdata = 36'h9_8765_4321;
    cyc("R7");
    go_start('h42, 0); gw_n = 1; cyc("R7");
    start = 0;
    cyc("R7"); expect_word("R7 all lanes", 36'h9_8765_4321);
    idle(); cyc("R7");

    // R8 each chip select in turn deselects
    for (int v = 0; v < 3; v++) begin
      go_start('h12, 0); cyc("R8");
      go_start('h13, 0);
      if (v == 0) cs_a = 0; else if (v == 1) cs_b_n = 1; else cs_c_n = 1;
      cyc("R8"); expect_word("R8 last word", pat('h12));
      idle(); adv = 1;
      cyc("R8");
      want("R8 off", rdata_oe === 1'b0, DW'(rdata_oe), '0);
      cyc("R8");
      want("R8 stays off", rdata_oe === 1'b0, DW'(rdata_oe), '0);
      idle();
    end

    // R9 output enable acts without a clock
    go_start('h20, 0); cyc("R9");
    start = 0; cyc("R9");
    oe_n = 1; #1;
    want("R9 oe off", rdata_oe === 1'b0 && rdata === '0, rdata, '0);
    oe_n = 0; #1;
    want("R9 oe on", rdata_oe === 1'b1 && rdata === pat('h20), rdata, pat('h20));
    idle(); cyc("R9");

    // R10 sleep freezes the burst and blocks a write
    go_start('h50, 1); cyc("R10");
    start = 0; adv = 1;
    cyc("R10"); expect_word("R10 before sleep", pat('h50));
    sleep = 1; go_start('h50, 1); gw_n = 0; wdata = 36'hF_FFFF_0000;
    cyc("R10");
    want("R10 off in sleep", rdata_oe === 1'b0, DW'(rdata_oe), '0);
    cyc("R10");
    sleep = 0; start = 0; adv = 1; gw_n = 1; #1;
    want("R10 slot kept", rdata_oe === 1'b1 && rdata === pat('h50), rdata, pat('h50));
    cyc("R10"); expect_word("R10 resumed", pat('h51));
    adv = 0;
    cyc("R10"); expect_word("R10 resumed2", pat('h52));
    go_start('h50, 1); cyc("R10");
    start = 0; cyc("R10"); expect_word("R10 no write", pat('h50));
    idle(); cyc("R10");

    // R2 mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      start  = ($urandom % 10) < 3;
      if (start) begin addr = 8'($urandom); linear = 1'($urandom); end
      adv    = 1'($urandom);
      cs_a   = ($urandom % 20) != 0;
      cs_b_n = ($urandom % 20) == 0;
      cs_c_n = ($urandom % 20) == 0;
      gw_n   = ($urandom % 10) != 0;
      bw_n   = ($urandom % 5) != 0;
      be_n   = 4'($urandom);
      wdata  = 36'({$urandom, $urandom});
      sleep  = ($urandom % 20) == 0;
      oe_n   = ($urandom % 10) == 0;
      cyc("R2");
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule